// File: doc/BRIEF.md
# Burst Dimming PWM Generator

This block produces the slow on/off enable that gates lamp current in a backlight inverter. A digital triangle ramp climbs from a low end-point code to a high end-point code, then drops back. It rises one `RISE_STEP` per clock and falls `FALL_STEP` (twice as much) per clock, so the climb lasts twice as long as the drop. The lamp enable comes from comparing the ramp with a dimming-level code, in the direction set by a polarity. That polarity is derived from an analog-dimming level code through a hysteresis band.

The block also has two overriding modes. Striking mode bypasses dimming and holds the lamp enable on. Shutdown parks the ramp at a fault code and forces the enable low. Each time the ramp turns at its low end point, the block emits a one-clock burst tick. Protection counters elsewhere use this tick as their time base.

Codes use 32 counts per volt-equivalent unit at the defaults: low end 16 (0.5), high end 64 (2.0), fault 128 (4.0), polarity thresholds 96 (3.0) and 112 (3.5).

Top module: `burst_dim_pwm`

## Requirements
- R1: While `rst` is high and on the first clocks after it: `ramp_o` = 16, the ramp is rising, `lamp_on_o` = 0, `burst_tick_o` = 0, and the polarity is positive.
- R2: When not in shutdown and rising, `ramp_o` increases by 1 each clock. When it would reach or pass 64, it takes the value 64 and turns downward.
- R3: When not in shutdown and falling, `ramp_o` decreases by 2 each clock. When it would reach or pass 16, it takes the value 16 and turns upward. With fixed inputs the period is 72 clocks.
- R4: `burst_tick_o` is high for exactly one clock: the clock in which `ramp_o` first shows 16 after falling. No tick is produced in shutdown.
- R5: Positive polarity, not striking, not shut down: `lamp_on_o` is 1 when the dimming code is strictly greater than the ramp value of the previous clock. So dimming 16 gives 0 on-clocks per period, 40 gives 35, and 65 gives 72.
- R6: Negative polarity, not striking, not shut down: `lamp_on_o` is 1 when the dimming code is strictly less than the ramp value of the previous clock. So dimming 15 gives 72 on-clocks per period, 40 gives 35, and 64 gives 0.
- R7: Polarity is updated only on the clock edge that produces a burst tick. At that edge, an analog-dimming code below 96 selects positive, a code above 112 selects negative, and a code from 96 to 112 keeps the previous polarity. Changes between ticks have no effect.
- R8: With `strike_i` high and `shutdown_i` low, `lamp_on_o` is 1 from the next clock on, whatever the dimming code.
- R9: With `shutdown_i` high, `ramp_o` is 128 and `lamp_on_o` is 0 from the next clock on, and `strike_i` is overridden. After release, the ramp falls by 2 per clock to 16. That takes 56 clocks and ends with a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dim_lvl_i | input | CODE_W | Burst dimming level code |
| adim_lvl_i | input | CODE_W | Analog dimming level code, used for polarity selection |
| strike_i | input | 1 | Striking mode: lamp held on |
| shutdown_i | input | 1 | Shutdown: ramp parked at fault code, lamp off |
| lamp_on_o | output | 1 | Registered lamp-on enable |
| burst_tick_o | output | 1 | One-clock pulse at each low turn of the ramp |
| ramp_o | output | CODE_W | Current ramp code |

## Verification
The comparator is driven with dimming codes at and just past each end point (15, 16, 64, 65) and at a mid value, 40, in both polarities. Counting on-clocks over a whole period separates a correct strict compare from an inclusive one, and separates positive from negative sense. Analog-dimming codes are stepped across the band (120, then 100, then 50), with the change applied right after a tick. This shows the hysteresis holding and shows that a mid-cycle change waits for the next tick. Striking with a dimming code that would otherwise keep the lamp dark, and shutdown asserted on top of striking, separate the two overrides. The 56-clock recovery from the fault code confirms the fall slope from a non-standard start.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {POL_POS = 1'b0, POL_NEG = 1'b1} burst_pol_e;
  typedef enum logic {RAMP_UP = 1'b0, RAMP_DOWN = 1'b1} ramp_dir_e;
endpackage

// File: rtl/burst_ramp_gen.sv
module burst_ramp_gen
  import burst_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int LO     = 16,
  parameter int HI     = 64,
  parameter int FAULT  = 128,
  parameter int RISE   = 1,
  parameter int FALL   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt_i,
  output logic [CODE_W-1:0] ramp_o,
  output logic              turn_low_o,
  output logic              tick_o
);
  localparam logic [CODE_W-1:0] LO_C      = CODE_W'(LO);
  localparam logic [CODE_W-1:0] HI_C      = CODE_W'(HI);
  localparam logic [CODE_W-1:0] FAULT_C   = CODE_W'(FAULT);
  localparam logic [CODE_W-1:0] RISE_C    = CODE_W'(RISE);
  localparam logic [CODE_W-1:0] FALL_C    = CODE_W'(FALL);
  localparam logic [CODE_W-1:0] UP_TURN_C = CODE_W'(HI - RISE);
  localparam logic [CODE_W-1:0] DN_TURN_C = CODE_W'(LO + FALL);

  logic [CODE_W-1:0] ramp_q, ramp_d;
  ramp_dir_e         dir_q, dir_d;
  logic              turn_low, tick_q;

  always_comb begin
    ramp_d   = ramp_q;
    dir_d    = dir_q;
    turn_low = 1'b0;
    if (halt_i) begin
      ramp_d = FAULT_C;
      dir_d  = RAMP_DOWN;
    end else if (dir_q == RAMP_UP) begin
      if (ramp_q >= UP_TURN_C) begin
        ramp_d = HI_C;
        dir_d  = RAMP_DOWN;
      end else begin
        ramp_d = ramp_q + RISE_C;
      end
    end else begin
      if (ramp_q <= DN_TURN_C) begin
        ramp_d   = LO_C;
        dir_d    = RAMP_UP;
        turn_low = 1'b1;
      end else begin
        ramp_d = ramp_q - FALL_C;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ramp_q <= LO_C;
      dir_q  <= RAMP_UP;
      tick_q <= 1'b0;
    end else begin
      ramp_q <= ramp_d;
      dir_q  <= dir_d;
      tick_q <= turn_low;
    end
  end

  assign ramp_o     = ramp_q;
  assign turn_low_o = turn_low;
  assign tick_o     = tick_q;

  assert_fault_park_R9: assert property (@(posedge clk) disable iff (rst)
    halt_i |=> (ramp_q == FAULT_C && !tick_q));
  assert_rise_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!halt_i && dir_q == RAMP_UP && ramp_q < UP_TURN_C) |=> (ramp_q == $past(ramp_q) + RISE_C));
  assert_fall_step_R3: assert property (@(posedge clk) disable iff (rst)
    (!halt_i && dir_q == RAMP_DOWN && ramp_q > DN_TURN_C) |=> (ramp_q == $past(ramp_q) - FALL_C));
  assert_tick_at_low_R4: assert property (@(posedge clk) disable iff (rst)
    tick_q |-> (ramp_q == LO_C && dir_q == RAMP_UP));
  assert_tick_single_R4: assert property (@(posedge clk) disable iff (rst)
    tick_q |=> !tick_q);
endmodule

// File: rtl/burst_pol_sel.sv
module burst_pol_sel
  import burst_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int POS_TH = 96,
  parameter int NEG_TH = 112
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_i,
  input  logic [CODE_W-1:0] adim_i,
  output burst_pol_e        pol_o
);
  localparam logic [CODE_W-1:0] POS_TH_C = CODE_W'(POS_TH);
  localparam logic [CODE_W-1:0] NEG_TH_C = CODE_W'(NEG_TH);

  burst_pol_e pol_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q <= POL_POS;
    end else if (sample_i) begin
      if (adim_i < POS_TH_C)      pol_q <= POL_POS;
      else if (adim_i > NEG_TH_C) pol_q <= POL_NEG;
    end
  end

  assign pol_o = pol_q;

  assert_pol_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !sample_i |=> $stable(pol_q));
  assert_pol_band_R7: assert property (@(posedge clk) disable iff (rst)
    (sample_i && adim_i >= POS_TH_C && adim_i <= NEG_TH_C) |=> $stable(pol_q));
endmodule

// File: rtl/burst_lamp_gate.sv
module burst_lamp_gate
  import burst_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] dim_i,
  input  logic [CODE_W-1:0] ramp_i,
  input  burst_pol_e        pol_i,
  input  logic              strike_i,
  input  logic              halt_i,
  output logic              lamp_o
);
  logic lamp_q, cmp_on;

  always_comb begin
    if (pol_i == POL_POS) cmp_on = (dim_i > ramp_i);
    else                  cmp_on = (dim_i < ramp_i);
  end

  always_ff @(posedge clk) begin
    if (rst)           lamp_q <= 1'b0;
    else if (halt_i)   lamp_q <= 1'b0;
    else if (strike_i) lamp_q <= 1'b1;
    else               lamp_q <= cmp_on;
  end

  assign lamp_o = lamp_q;

  assert_dark_in_shutdown_R9: assert property (@(posedge clk) disable iff (rst)
    halt_i |=> !lamp_q);
  assert_strike_on_R8: assert property (@(posedge clk) disable iff (rst)
    (strike_i && !halt_i) |=> lamp_q);
endmodule

// File: rtl/burst_dim_pwm.sv
module burst_dim_pwm
  import burst_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int RAMP_LO    = 16,
  parameter int RAMP_HI    = 64,
  parameter int FAULT_CODE = 128,
  parameter int RISE_STEP  = 1,
  parameter int FALL_STEP  = 2,
  parameter int POL_POS_TH = 96,
  parameter int POL_NEG_TH = 112
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] dim_lvl_i,
  input  logic [CODE_W-1:0] adim_lvl_i,
  input  logic              strike_i,
  input  logic              shutdown_i,
  output logic              lamp_on_o,
  output logic              burst_tick_o,
  output logic [CODE_W-1:0] ramp_o
);
  logic [CODE_W-1:0] ramp;
  logic              turn_low;
  burst_pol_e        pol;

  burst_ramp_gen #(
    .CODE_W(CODE_W), .LO(RAMP_LO), .HI(RAMP_HI), .FAULT(FAULT_CODE),
    .RISE(RISE_STEP), .FALL(FALL_STEP)
  ) u_ramp (
    .clk(clk), .rst(rst), .halt_i(shutdown_i),
    .ramp_o(ramp), .turn_low_o(turn_low), .tick_o(burst_tick_o)
  );

  burst_pol_sel #(
    .CODE_W(CODE_W), .POS_TH(POL_POS_TH), .NEG_TH(POL_NEG_TH)
  ) u_pol (
    .clk(clk), .rst(rst), .sample_i(turn_low), .adim_i(adim_lvl_i), .pol_o(pol)
  );

  burst_lamp_gate #(.CODE_W(CODE_W)) u_gate (
    .clk(clk), .rst(rst), .dim_i(dim_lvl_i), .ramp_i(ramp), .pol_i(pol),
    .strike_i(strike_i), .halt_i(shutdown_i), .lamp_o(lamp_on_o)
  );

  assign ramp_o = ramp;

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (ramp_o == CODE_W'(RAMP_LO) && !lamp_on_o && !burst_tick_o && pol == POL_POS));
endmodule

// File: tb/tb_burst_dim_pwm.sv
`timescale 1ns/1ps
module tb_burst_dim_pwm;
  localparam int W = 8;
  localparam real HALF = 2.5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] dim = 8'd40;
  logic [W-1:0] adim = 8'd0;
  logic strike = 1'b0;
  logic sd = 1'b0;
  logic lamp, tick;
  logic [W-1:0] ramp;

  int n_chk = 0;
  int n_fail = 0;
  string lamp_req = "R5";
  bit model_ok = 0;
  bit done = 0;

  int m_ramp, m_pol, m_lamp, m_tick;
  bit m_up;

  always #(HALF) clk = ~clk;

  burst_dim_pwm dut (
    .clk(clk), .rst(rst), .dim_lvl_i(dim), .adim_lvl_i(adim),
    .strike_i(strike), .shutdown_i(sd), .lamp_on_o(lamp),
    .burst_tick_o(tick), .ramp_o(ramp)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model, stepped at each rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_ramp = 16; m_up = 1; m_pol = 0; m_lamp = 0; m_tick = 0;
      model_ok = 1;
    end else begin
      int prev_ramp, nxt;
      bit turned;
      prev_ramp = m_ramp;
      turned = 0;
      if (sd) m_lamp = 0;
      else if (strike) m_lamp = 1;
      else if (m_pol == 0) m_lamp = (int'(dim) > prev_ramp) ? 1 : 0;
      else m_lamp = (int'(dim) < prev_ramp) ? 1 : 0;
      if (sd) begin
        m_ramp = 128; m_up = 0;
      end else if (m_up) begin
        nxt = m_ramp + 1;
        if (nxt >= 64) begin m_ramp = 64; m_up = 0; end
        else m_ramp = nxt;
      end else begin
        nxt = m_ramp - 2;
        if (nxt <= 16) begin m_ramp = 16; m_up = 1; turned = 1; end
        else m_ramp = nxt;
      end
      m_tick = turned;
      if (turned) begin
        if (adim < 8'd96) m_pol = 0;
        else if (adim > 8'd112) m_pol = 1;
      end
    end
  end

  // Per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (model_ok && !rst && !done) begin
      chk("R2", "ramp", int'(ramp), m_ramp);
      chk("R4", "tick", int'(tick), m_tick);
      chk(lamp_req, "lamp", int'(lamp), m_lamp);
    end
  end

  task automatic wait_tick();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (tick) return;
    end
    chk("R4", "tick timeout", 0, 1);
  endtask

  task automatic count_on(output int on);
    on = 0;
    for (int i = 0; i < 72; i++) begin
      @(negedge clk);
      on += int'(lamp);
    end
  endtask

  task automatic report();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(HALF * 2 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int on, gap, mx;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "ramp in reset", int'(ramp), 16);
    chk("R1", "lamp in reset", int'(lamp), 0);
    chk("R1", "tick in reset", int'(tick), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "ramp rising after reset", int'(ramp), 17);

    // R2 / R3 / R4 period, peak and tick spacing
    wait_tick();
    @(negedge clk);
    chk("R2", "first rising step after tick", int'(ramp), 17);
    mx = 0; gap = 1;
    while (!tick && gap < 400) begin
      @(negedge clk);
      gap++;
      if (int'(ramp) > mx) mx = int'(ramp);
    end
    chk("R3", "tick period", gap, 72);
    chk("R2", "ramp peak", mx, 64);

    // R5 positive duty at several levels
    lamp_req = "R5";
    dim = 8'd40; repeat (2) @(negedge clk); count_on(on); chk("R5", "on clocks dim40", on, 35);
    dim = 8'd16; repeat (2) @(negedge clk); count_on(on); chk("R5", "on clocks dim16", on, 0);
    dim = 8'd65; repeat (2) @(negedge clk); count_on(on); chk("R5", "on clocks dim65", on, 72);

    // R7 switch to negative; mid-cycle change ignored
    lamp_req = "R7";
    dim = 8'd15;
    wait_tick();
    adim = 8'd120;
    repeat (10) @(negedge clk);
    chk("R7", "polarity unchanged mid-cycle", int'(lamp), 0);
    wait_tick();
    @(negedge clk);
    chk("R7", "negative after tick", int'(lamp), 1);
    adim = 8'd100;
    wait_tick();
    repeat (3) @(negedge clk);
    chk("R7", "band keeps negative", int'(lamp), 1);

    // R6 negative duty
    lamp_req = "R6";
    count_on(on); chk("R6", "on clocks dim15", on, 72);
    dim = 8'd40; repeat (2) @(negedge clk); count_on(on); chk("R6", "on clocks dim40", on, 35);
    dim = 8'd64; repeat (2) @(negedge clk); count_on(on); chk("R6", "on clocks dim64", on, 0);

    // back to positive
    lamp_req = "R7";
    adim = 8'd50;
    wait_tick();
    @(negedge clk);
    chk("R7", "positive after tick dim64", int'(lamp), 1);
    wait_tick();

    // R8 striking overrides dimming
    lamp_req = "R8";
    dim = 8'd16; strike = 1'b1;
    @(negedge clk);
    chk("R8", "lamp on next clock", int'(lamp), 1);
    count_on(on); chk("R8", "on clocks while striking", on, 72);

    // R9 shutdown over striking
    lamp_req = "R9";
    sd = 1'b1;
    @(negedge clk);
    chk("R9", "ramp parked", int'(ramp), 128);
    chk("R9", "lamp off", int'(lamp), 0);
    on = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); on += int'(tick) + int'(lamp); end
    chk("R9", "no tick or lamp in shutdown", on, 0);
    strike = 1'b0; dim = 8'd40;
    sd = 1'b0;
    gap = 0;
    do begin @(negedge clk); gap++; end while (!tick && gap < 400);
    chk("R9", "clocks to first tick after release", gap, 56);
    lamp_req = "R5";
    count_on(on); chk("R5", "duty after recovery", on, 35);

    report();
  end
endmodule